// File: doc/BRIEF.md
# Page-Clipped Serial Flash Read and Power Sequencer

This block sits between a requester and a byte-level serial shifter that talks to a NOR flash. A read request carries a start address and a requested length. The block trims the length so that the transfer stays inside one flash page and inside the device. It then drives the read command, the address bytes and the data-clock bytes through the shifter, all under a single chip-select assertion. Each received byte goes out on a valid/ready stream. A one-cycle done pulse reports how many bytes were actually delivered. A requester that wants more bytes issues a further request at the next address.

A power request sends one command byte on its own: sleep puts the flash into deep power-down, and wake brings it back. A start address beyond the device completes at once with an error flag and no bus activity. So does a reserved operation code. A request that trims to zero bytes completes with a count of zero and no bus activity. When the output stream stalls, the block stops clocking the flash, so no byte is ever dropped.

Top module: `flash_rd_pwr`

## Requirements
- R1: A read with a non-zero trimmed length drives, inside one chip-select low period, the byte 0x03, then the start address as ADDR_BYTES bytes with the most significant byte first, then one dummy 0x00 byte per data byte. The received bytes appear in order on the output stream.
- R2: A read whose start address is strictly greater than DEV_BYTES completes with done_err=1 and done_count=0. It performs no shifter transfer and never lowers chip select.
- R3: The delivered length never exceeds PAGE_BYTES, even when the request asks for more.
- R4: The delivered length never runs past the device end, so a start address equal to DEV_BYTES delivers zero bytes without an error.
- R5: If the range left after R3 and R4 still spans two pages, the length becomes the number of bytes from the start address to the end of its page.
- R6: A trimmed length of zero, whether from a zero request or from R4, completes with done_err=0, done_count=0 and no shifter transfer.
- R7: Operation code 2'b01 sends the single byte 0xB9 and code 2'b10 sends the single byte 0xAB. Each of these runs in its own chip-select low period and completes with done_count=0 and done_err=0. Code 2'b00 is a read.
- R8: The reserved operation code 2'b11 completes with done_err=1 and done_count=0, and it causes no shifter transfer.
- R9: done is a one-cycle pulse, chip select is high while done is high, and done_count equals the number of bytes handed over on the output stream for that request.
- R10: While dout_valid is high and dout_ready is low, dout_valid and dout_data hold their values. No shifter transfer is requested while an output byte is pending.
- R11: Once xfer_req is raised, xfer_req and xfer_tx hold until xfer_ack is seen.
- R12: After reset, req_ready=1, spi_cs_n=1, xfer_req=0, dout_valid=0 and done=0. Requests are accepted only while req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_op | input | 2 | 00 read, 01 sleep, 10 wake, 11 reserved |
| req_addr | input | 8*ADDR_BYTES | Read start byte address |
| req_len | input | LEN_W | Requested read length in bytes |
| spi_cs_n | output | 1 | Flash chip select, active low |
| xfer_req | output | 1 | Byte transfer request to the shifter |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_ack | input | 1 | Shifter finished the current byte (one-cycle pulse) |
| xfer_rx | input | 8 | Byte shifted in, valid with xfer_ack |
| dout_valid | output | 1 | Output byte valid |
| dout_data | output | 8 | Output byte |
| dout_ready | input | 1 | Consumer accepts the output byte |
| done | output | 1 | Request complete, one cycle |
| done_err | output | 1 | Request rejected, valid with done |
| done_count | output | $clog2(PAGE_BYTES)+1 | Bytes delivered, valid with done |

## Verification
A request is taken on the clock edge where req_valid and req_ready are both high. The first command byte is offered on xfer_req in the next cycle. A rejected or empty request raises done exactly one cycle after acceptance. Otherwise done rises one cycle after the final output byte is handed over, or one cycle after the power command is acknowledged. The bench does not predict these edges with fixed delays, because the shifter and the consumer it models stall at random. Instead it samples on falling edges, polls for done within a bounded wait, and compares the result fields in that same cycle. Bus logs are compared two cycles later, once chip select has been seen high again.

// File: rtl/flr_pkg.sv
package flr_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_SLEEP = 2'b01,
    OP_WAKE  = 2'b10,
    OP_RSVD  = 2'b11
  } flr_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_DONE
  } flr_st_e;

  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_SLEEP = 8'hB9;
  localparam logic [7:0] CMD_WAKE  = 8'hAB;
  localparam logic [7:0] CMD_DUMMY = 8'h00;

endpackage

// File: rtl/flr_clip.sv
module flr_clip #(
  parameter int          AW         = 24,
  parameter int          LEN_W      = 12,
  parameter int          PAGE_BYTES = 256,
  parameter int unsigned DEV_BYTES  = 65536
) (
  input  logic [AW-1:0]                  addr,
  input  logic [LEN_W-1:0]               len,
  output logic                           oob,
  output logic [$clog2(PAGE_BYTES):0]    clip_len
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = PW + 1;
  localparam int WW = ((AW > LEN_W) ? AW : LEN_W) + 2;

  logic [WW-1:0] a_w, l_w, dev_w, page_w;
  logic [WW-1:0] room, lim_pg, lim_dev, last_b, to_pg_end, res;
  logic          spans;

  always_comb begin
    a_w       = WW'(addr);
    l_w       = WW'(len);
    dev_w     = WW'(DEV_BYTES);
    page_w    = WW'(PAGE_BYTES);
    oob       = a_w > dev_w;
    room      = oob ? '0 : (dev_w - a_w);
    lim_pg    = (l_w > page_w) ? page_w : l_w;
    lim_dev   = (lim_pg > room) ? room : lim_pg;
    last_b    = a_w + lim_dev - WW'(1);
    spans     = (lim_dev != '0) && ((a_w >> PW) != (last_b >> PW));
    to_pg_end = page_w - WW'(addr[PW-1:0]);
    res       = spans ? to_pg_end : lim_dev;
    clip_len  = CW'(res);
  end

endmodule

// File: rtl/flr_obuf.sv
module flr_obuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       taken
);
  logic       v_q, v_d;
  logic [7:0] d_q, d_d;
  logic       d_en;

  always_comb begin
    taken = v_q && out_ready;
    v_d   = v_q;
    if (taken) v_d = 1'b0;
    if (load)  v_d = 1'b1;
    d_en  = load;
    d_d   = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= 8'h00;
    end else begin
      v_q <= v_d;
      if (d_en) d_q <= d_d;
    end
  end

  assign out_valid = v_q;
  assign out_data  = d_q;

endmodule

// File: rtl/flr_seq.sv
module flr_seq
  import flr_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int PAGE_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_op,
  input  logic [8*ADDR_BYTES-1:0]       req_addr,
  input  logic [$clog2(PAGE_BYTES):0]   clip_len,
  input  logic                          clip_oob,
  output logic                          spi_cs_n,
  output logic                          xfer_req,
  output logic [7:0]                    xfer_tx,
  input  logic                          xfer_ack,
  input  logic [7:0]                    xfer_rx,
  output logic                          buf_load,
  output logic [7:0]                    buf_data,
  input  logic                          buf_valid,
  input  logic                          buf_taken,
  output logic                          done,
  output logic                          done_err,
  output logic [$clog2(PAGE_BYTES):0]   done_count
);
  localparam int AW  = 8 * ADDR_BYTES;
  localparam int CW  = $clog2(PAGE_BYTES) + 1;
  localparam int AIW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  flr_st_e        st_q, st_d;
  flr_op_e        op_q, op_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [CW-1:0]  len_q, len_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [AIW-1:0] aidx_q, aidx_d;
  logic           err_q, err_d;
  logic           accept;
  logic [7:0]     cmd_byte;
  logic [7:0]     abyte [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
    assign abyte[g] = addr_q[8*g +: 8];
  end

  always_comb begin
    case (op_q)
      OP_SLEEP: cmd_byte = CMD_SLEEP;
      OP_WAKE:  cmd_byte = CMD_WAKE;
      default:  cmd_byte = CMD_READ;
    endcase
  end

  // next-state process
  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    addr_d = addr_q;
    len_d  = len_q;
    cnt_d  = cnt_q;
    aidx_d = aidx_q;
    err_d  = err_q;
    accept = (st_q == ST_IDLE) && req_valid;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          op_d   = flr_op_e'(req_op);
          addr_d = req_addr;
          len_d  = clip_len;
          cnt_d  = '0;
          err_d  = 1'b0;
          aidx_d = AIW'(ADDR_BYTES - 1);
          if (flr_op_e'(req_op) == OP_RSVD ||
              (flr_op_e'(req_op) == OP_READ && clip_oob)) begin
            err_d = 1'b1;
            st_d  = ST_DONE;
          end else if (flr_op_e'(req_op) == OP_READ && clip_len == '0) begin
            st_d = ST_DONE;
          end else begin
            st_d = ST_CMD;
          end
        end
      end
      ST_CMD: begin
        if (xfer_ack) st_d = (op_q == OP_READ) ? ST_ADDR : ST_DONE;
      end
      ST_ADDR: begin
        if (xfer_ack) begin
          if (aidx_q == '0) st_d = ST_DATA;
          else              aidx_d = aidx_q - AIW'(1);
        end
      end
      ST_DATA: begin
        if (xfer_ack) cnt_d = cnt_q + CW'(1);
        if (buf_taken && cnt_q == len_q) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_READ;
      addr_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      aidx_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      len_q  <= len_d;
      cnt_q  <= cnt_d;
      aidx_q <= aidx_d;
      err_q  <= err_d;
    end
  end

  // outputs
  always_comb begin
    req_ready  = (st_q == ST_IDLE);
    spi_cs_n   = !(st_q == ST_CMD || st_q == ST_ADDR || st_q == ST_DATA);
    xfer_req   = (st_q == ST_CMD) || (st_q == ST_ADDR) ||
                 ((st_q == ST_DATA) && !buf_valid && (cnt_q != len_q));
    case (st_q)
      ST_CMD:  xfer_tx = cmd_byte;
      ST_ADDR: xfer_tx = abyte[aidx_q];
      default: xfer_tx = CMD_DUMMY;
    endcase
    buf_load   = (st_q == ST_DATA) && xfer_ack;
    buf_data   = xfer_rx;
    done       = (st_q == ST_DONE);
    done_err   = err_q;
    done_count = cnt_q;
  end

endmodule

// File: rtl/flash_rd_pwr.sv
module flash_rd_pwr #(
  parameter int          ADDR_BYTES = 3,
  parameter int          PAGE_BYTES = 256,
  parameter int unsigned DEV_BYTES  = 65536,
  parameter int          LEN_W      = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_op,
  input  logic [8*ADDR_BYTES-1:0]       req_addr,
  input  logic [LEN_W-1:0]              req_len,
  output logic                          spi_cs_n,
  output logic                          xfer_req,
  output logic [7:0]                    xfer_tx,
  input  logic                          xfer_ack,
  input  logic [7:0]                    xfer_rx,
  output logic                          dout_valid,
  output logic [7:0]                    dout_data,
  input  logic                          dout_ready,
  output logic                          done,
  output logic                          done_err,
  output logic [$clog2(PAGE_BYTES):0]   done_count
);
  localparam int AW = 8 * ADDR_BYTES;
  localparam int CW = $clog2(PAGE_BYTES) + 1;

  logic [1:0]    rst_sync_q;
  logic          rst_n_i;
  logic [CW-1:0] clip_len;
  logic          clip_oob;
  logic          buf_load, buf_taken;
  logic [7:0]    buf_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  flr_clip #(
    .AW(AW), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .DEV_BYTES(DEV_BYTES)
  ) u_clip (
    .addr(req_addr), .len(req_len), .oob(clip_oob), .clip_len(clip_len)
  );

  flr_seq #(
    .ADDR_BYTES(ADDR_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .clip_len(clip_len), .clip_oob(clip_oob),
    .spi_cs_n(spi_cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
    .buf_load(buf_load), .buf_data(buf_data),
    .buf_valid(dout_valid), .buf_taken(buf_taken),
    .done(done), .done_err(done_err), .done_count(done_count)
  );

  flr_obuf u_obuf (
    .clk(clk), .rst_n(rst_n_i),
    .load(buf_load), .load_data(buf_data),
    .out_ready(dout_ready), .out_valid(dout_valid),
    .out_data(dout_data), .taken(buf_taken)
  );

endmodule

// File: rtl/flr_checker.sv
module flr_checker #(
  parameter int PAGE_BYTES = 256,
  parameter int CW         = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          spi_cs_n,
  input logic          xfer_req,
  input logic [7:0]    xfer_tx,
  input logic          xfer_ack,
  input logic          dout_valid,
  input logic [7:0]    dout_data,
  input logic          dout_ready,
  input logic          done,
  input logic          done_err,
  input logic [CW-1:0] done_count
);

  AST_XFER_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !spi_cs_n);                                          // R1

  AST_ERR_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err) |-> (done_count == '0));                       // R2

  AST_COUNT_WITHIN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_count <= CW'(PAGE_BYTES)));                        // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                  // R9

  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n);                                               // R9

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data))); // R10

  AST_NO_XFER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> !xfer_req);                                        // R10

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));      // R11

  AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (spi_cs_n && !dout_valid));                         // R12

endmodule

bind flash_rd_pwr flr_checker #(
  .PAGE_BYTES(PAGE_BYTES), .CW($clog2(PAGE_BYTES) + 1)
) u_flr_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .spi_cs_n(spi_cs_n),
  .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack),
  .dout_valid(dout_valid), .dout_data(dout_data), .dout_ready(dout_ready),
  .done(done), .done_err(done_err), .done_count(done_count)
);

// File: tb/flash_rd_pwr_test.sv
`timescale 1ns/1ps
module flash_rd_pwr_test;
  localparam int AB    = 3;
  localparam int PAGE  = 256;
  localparam int DEV   = 65536;
  localparam int LEN_W = 12;
  localparam int AW    = 8 * AB;
  localparam int CW    = $clog2(PAGE) + 1;

  logic            clk, rst_n;
  logic            req_valid, req_ready;
  logic [1:0]      req_op;
  logic [AW-1:0]   req_addr;
  logic [LEN_W-1:0] req_len;
  logic            spi_cs_n, xfer_req, xfer_ack;
  logic [7:0]      xfer_tx, xfer_rx;
  logic            dout_valid, dout_ready;
  logic [7:0]      dout_data;
  logic            done, done_err;
  logic [CW-1:0]   done_count;

  flash_rd_pwr uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .spi_cs_n(spi_cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .dout_valid(dout_valid),
    .dout_data(dout_data), .dout_ready(dout_ready), .done(done),
    .done_err(done_err), .done_count(done_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int  n_checks = 0, n_errs = 0;
  bit  finished = 0;
  bit  models_on = 0;

  // bus and stream logs
  logic [7:0] spi_log [0:1023];
  logic [7:0] rx_log  [0:1023];
  int spi_n, rx_n, trans_n;
  int idx, wait_c, addr_acc;
  bit prev_cs;
  bit stall_x, stall_d, prev_done;
  logic [7:0] stall_tx, stall_dat;
  int viol_r10, viol_r11, viol_r9;

  function automatic logic [7:0] fmem(input int a);
    logic [31:0] v;
    v = a;
    return v[7:0] ^ v[15:8] ^ v[23:16] ^ 8'h3C;
  endfunction

  function automatic int exp_len(input int a, input int l, output bit err);
    int r;
    err = (a > DEV);
    if (err) return 0;
    r = (l > PAGE) ? PAGE : l;
    if (a + r > DEV) r = DEV - a;
    if (r > 0 && (a / PAGE) != ((a + r - 1) / PAGE)) r = PAGE - (a % PAGE);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // shifter, consumer and protocol monitors, all on falling edges
  always @(negedge clk) begin
    if (models_on) begin
      if (prev_done && done) viol_r9++;
      prev_done = done;
      if (stall_x && !(xfer_req && xfer_tx == stall_tx)) viol_r11++;
      if (stall_d && !(dout_valid && dout_data == stall_dat)) viol_r10++;
      if (dout_valid && xfer_req) viol_r10++;
      if (!prev_cs && spi_cs_n) trans_n++;
      prev_cs = spi_cs_n;
      if (spi_cs_n) begin idx = 0; addr_acc = 0; end
      // shifter model
      if (xfer_req && wait_c == 0) begin
        xfer_ack = 1'b1;
        spi_log[spi_n % 1024] = xfer_tx;
        spi_n++;
        if (idx >= 1 && idx <= AB) addr_acc = (addr_acc << 8) | int'(xfer_tx);
        xfer_rx = (idx > AB) ? fmem(addr_acc + idx - 1 - AB) : 8'hFF;
        idx++;
        wait_c = $urandom_range(0, 2);
      end else begin
        xfer_ack = 1'b0;
        if (xfer_req) wait_c--;
      end
      stall_x  = xfer_req && !xfer_ack;
      stall_tx = xfer_tx;
      // consumer model
      dout_ready = ($urandom_range(0, 9) < 6);
      if (dout_valid && dout_ready) begin
        rx_log[rx_n % 1024] = dout_data;
        rx_n++;
      end
      stall_d   = dout_valid && !dout_ready;
      stall_dat = dout_data;
    end
  end

  task automatic clear_logs();
    spi_n = 0; rx_n = 0; trans_n = 0;
  endtask

  task automatic run_op(input logic [1:0] op, input int a, input int l,
                        output bit got_err, output int got_cnt, output bit ok);
    int t;
    clear_logs();
    @(negedge clk);
    req_op = op; req_addr = AW'(a); req_len = LEN_W'(l); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0; ok = 1;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    if (!done) begin
      ok = 0;
      chk(0, "R9 done timeout", 0, 1);
    end
    got_err = done_err;
    got_cnt = int'(done_count);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input int a, input int l, input string tag);
    bit e_err, g_err, ok;
    int e_n, g_n;
    bit data_ok;
    e_n = exp_len(a, l, e_err);
    run_op(2'b00, a, l, g_err, g_n, ok);
    chk(g_err == e_err, {tag, " err flag"}, g_err, e_err);
    chk(g_n == e_n, {tag, " count"}, g_n, e_n);
    chk(rx_n == g_n, "R9 count vs stream", rx_n, g_n);
    if (e_n == 0) begin
      chk(spi_n == 0 && trans_n == 0, {tag, " no bus activity"}, spi_n, 0);
    end else begin
      data_ok = (spi_n == 1 + AB + e_n) && (spi_log[0] == 8'h03) && (trans_n == 1);
      for (int k = 0; k < AB; k++)
        if (spi_log[1+k] != 8'((a >> (8*(AB-1-k))) & 8'hFF)) data_ok = 0;
      for (int k = 0; k < e_n && k < rx_n; k++)
        if (rx_log[k] != fmem(a + k)) data_ok = 0;
      chk(data_ok, "R1 command, address and data", spi_n, 1 + AB + e_n);
    end
  endtask

  task automatic do_pwr(input logic [1:0] op, input logic [7:0] code, input string tag);
    bit g_err, ok; int g_n;
    run_op(op, 0, 0, g_err, g_n, ok);
    chk(!g_err && g_n == 0, {tag, " result"}, g_n, 0);
    chk(spi_n == 1 && spi_log[0] == code && trans_n == 1, {tag, " single byte"},
        int'(spi_log[0]), int'(code));
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_len = '0;
    xfer_ack = 1'b0; xfer_rx = 8'h00; dout_ready = 1'b0;
    idx = 0; wait_c = 0; addr_acc = 0; prev_cs = 1; stall_x = 0; stall_d = 0;
    prev_done = 0; viol_r9 = 0; viol_r10 = 0; viol_r11 = 0;
    stall_tx = 8'h00; stall_dat = 8'h00;
    clear_logs();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(req_ready && spi_cs_n && !xfer_req && !dout_valid && !done,
        "R12 reset state", {req_ready, spi_cs_n, xfer_req, dout_valid, done}, 5'b11000);
    models_on = 1;

    do_read(32'h0100, 16, "R1");
    do_read(0, 600, "R3");
    do_read(32'h01F0, 40, "R5");
    do_read(32'h0040, 600, "R3 R5");
    do_read(DEV - 10, 100, "R4");
    do_read(DEV, 5, "R4 R6");
    do_read(32'h0300, 0, "R6");
    do_read(DEV + 1, 8, "R2");
    do_read(32'hFFFFFF, 8, "R2");
    do_pwr(2'b01, 8'hB9, "R7 sleep");
    do_pwr(2'b10, 8'hAB, "R7 wake");
    begin
      bit g_err, ok; int g_n;
      run_op(2'b11, 32'h10, 4, g_err, g_n, ok);
      chk(g_err && g_n == 0, "R8 reserved op result", g_n, 0);
      chk(spi_n == 0 && trans_n == 0, "R8 reserved op no bus", spi_n, 0);
    end
    for (int i = 0; i < 30; i++) begin
      int a, l;
      a = (i % 4 == 0) ? (DEV - $urandom_range(0, 300)) : $urandom_range(0, DEV + 16);
      l = $urandom_range(0, 600);
      do_read(a, l, "R3 R4 R5 random");
    end

    chk(viol_r9 == 0, "R9 done pulse width", viol_r9, 0);
    chk(viol_r10 == 0, "R10 stream back-pressure", viol_r10, 0);
    chk(viol_r11 == 0, "R11 transfer hold", viol_r11, 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

endmodule